// File: doc/BRIEF.md
# Multi-Mode Preset Interval Counter

This block is an up-counter paired with a preset/buffer register, both reached through a single data register port. A prescaler supplies a one-cycle count pulse, and a run bit enables counting. A 2-bit mode selects one of two behaviours. In the interval modes, the counter starts from the preset value, climbs to all ones and wraps to zero. In the capture modes, the counter runs freely and an external trigger pulse copies its value into the preset/buffer register.

A write to the data port lands in both registers while the counter is stopped. While it runs, the write lands only in the preset. The read value is always the preset/buffer register, so in the capture modes it shows the most recent captured count. The block drives two outputs. The first is a one-cycle event pulse, raised on a wrap or on a capture. The second is a one-cycle request to clear the run bit, raised when a single interval completes. Flag storage, interrupts and the prescaler sit outside the block.

Top module: `preset_interval_timer`

## Requirements
- R1: After reset the read value is zero, and both the event pulse and the run-clear request are low.
- R2: The counter increases by one on a cycle where both the count pulse and the run bit are high. With the run bit low it holds its value.
- R3: A write with the run bit low loads the counter and the preset with the written value. A write with the run bit high loads only the preset. The read value is always the preset/buffer register.
- R4: Mode 2'b00 (single interval): an advance from all ones makes the counter zero, and raises the event pulse and the run-clear request for exactly one cycle. Both outputs appear in the cycle after that advance.
- R5: Mode 2'b00: after the wrap, the counter takes no further count pulses until the run bit has been low for at least one cycle.
- R6: Mode 2'b01 (repeat interval): an advance from all ones raises the event pulse and reloads the counter from the preset. Counting then continues, and no run-clear request is raised.
- R7: Mode 2'b10 (capture): a trigger pulse copies the counter value from before any advance in that cycle into the preset/buffer register, and raises the event pulse. This happens whether or not the counter is running. The capture takes priority over a data write in the same cycle.
- R8: Mode 2'b11 (capture and zero): the capture behaves as in R7, and the counter also becomes zero. This overrides a count pulse or a stopped write in the same cycle.
- R9: In modes 2'b10 and 2'b11, a wrap from all ones also raises the event pulse, and no run-clear request is raised.
- R10: In modes 2'b00 and 2'b01 the trigger input has no effect on the registers or the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | One-cycle count pulse from the prescaler |
| runBit | input | 1 | Counter enable (run bit) |
| modeSel | input | 2 | Operating mode: 00 single, 01 repeat, 10 capture, 11 capture and zero |
| trigIn | input | 1 | One-cycle capture trigger pulse |
| wrEn | input | 1 | Data register write strobe |
| wrData | input | WIDTH | Data register write value |
| rdData | output | WIDTH | Preset/buffer register value |
| ovfPulse | output | 1 | One-cycle event pulse (wrap or capture) |
| stopReq | output | 1 | One-cycle request to clear the run bit after a single interval |

## Verification
The bench drives the counter across the all-ones boundary in every mode and checks that the wrap produces the right result for each mode:
- Single mode must give exactly one event. A design that kept counting would show the extra advance at the next capture.
- Repeat mode must reload the preset. A preset written during the run must appear after the following wrap, which shows whether a running write touched the counter.
- The capture modes must capture the value from before the advance when a trigger and a count pulse coincide. An off-by-one capture shows up in the read value.
- Mode 2'b11 must clear the counter on the trigger, which the bench checks with a later capture.

A coincident capture and stopped write is also exercised, because a design that let the write win would return the written value instead of the old count.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'b00,
    MODE_REPEAT  = 2'b01,
    MODE_CAPTURE = 2'b10,
    MODE_CAPZERO = 2'b11
  } pitMode_e;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic incr;     // advance counter by one
    logic reload;   // counter <= preset
    logic clear;    // counter <= 0
    logic loadCnt;  // counter <= write data
    logic loadPre;  // preset <= write data
    logic capture;  // preset <= counter
  } pitStrobe_t;

  function automatic logic isCaptureMode(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pitStrobe_t       strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] cntVal,
  output logic [WIDTH-1:0] preVal,
  output logic             cntAllOnes
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cntQ, cntNext;
  logic [WIDTH-1:0] preQ, preNext;

  // Counter next value, highest priority first.
  always_comb begin
    if (strobe.clear)        cntNext = ZERO;
    else if (strobe.loadCnt) cntNext = wrData;
    else if (strobe.reload)  cntNext = preQ;
    else if (strobe.incr)    cntNext = cntQ + ONE;
    else                     cntNext = cntQ;
  end

  // Preset/buffer next value: capture beats a write.
  always_comb begin
    if (strobe.capture)      preNext = cntQ;
    else if (strobe.loadPre) preNext = wrData;
    else                     preNext = preQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= ZERO;
      preQ <= ZERO;
    end else begin
      cntQ <= cntNext;
      preQ <= preNext;
    end
  end

  assign cntVal     = cntQ;
  assign preVal     = preQ;
  assign cntAllOnes = &cntQ;

endmodule

// File: rtl/pit_control.sv
module pit_control
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       runBit,
  input  logic [1:0] modeSel,
  input  logic       trigIn,
  input  logic       wrEn,
  input  logic       cntAllOnes,
  output pitStrobe_t strobe,
  output logic       ovfPulse,
  output logic       stopReq
);

  pitMode_e mode;
  logic     haltQ;
  logic     advance;
  logic     wrapNow;
  logic     trigCap;
  logic     singleDone;
  logic     eventNow;
  logic     ovfQ, stopQ;

  assign mode       = pitMode_e'(modeSel);
  assign trigCap    = isCaptureMode(modeSel) & trigIn;
  assign advance    = runBit & tickIn & ~haltQ;
  assign wrapNow    = advance & cntAllOnes;
  assign singleDone = wrapNow & (mode == MODE_SINGLE);
  assign eventNow   = wrapNow | trigCap;

  always_comb begin
    strobe         = '0;
    strobe.incr    = advance;
    strobe.reload  = wrapNow & (mode == MODE_REPEAT);
    strobe.clear   = trigCap & (mode == MODE_CAPZERO);
    strobe.loadCnt = wrEn & ~runBit;
    strobe.loadPre = wrEn;
    strobe.capture = trigCap;
  end

  // Single interval: freeze after the wrap until the run bit drops.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltQ <= 1'b0;
      ovfQ  <= 1'b0;
      stopQ <= 1'b0;
    end else begin
      if (!runBit)         haltQ <= 1'b0;
      else if (singleDone) haltQ <= 1'b1;
      ovfQ  <= eventNow;
      stopQ <= singleDone;
    end
  end

  assign ovfPulse = ovfQ;
  assign stopReq  = stopQ;

endmodule

// File: rtl/preset_interval_timer.sv
module preset_interval_timer
  import pit_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             runBit,
  input  logic [1:0]       modeSel,
  input  logic             trigIn,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             ovfPulse,
  output logic             stopReq
);

  pitStrobe_t       strobe;
  logic [WIDTH-1:0] cntVal;
  logic             cntAllOnes;

  pit_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickIn     (tickIn),
    .runBit     (runBit),
    .modeSel    (modeSel),
    .trigIn     (trigIn),
    .wrEn       (wrEn),
    .cntAllOnes (cntAllOnes),
    .strobe     (strobe),
    .ovfPulse   (ovfPulse),
    .stopReq    (stopReq)
  );

  pit_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .cntVal     (cntVal),
    .preVal     (rdData),
    .cntAllOnes (cntAllOnes)
  );

endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickIn,
  input logic             runBit,
  input logic [1:0]       modeSel,
  input logic             trigIn,
  input logic             wrEn,
  input logic [WIDTH-1:0] wrData,
  input logic [WIDTH-1:0] rdData,
  input logic             ovfPulse,
  input logic             stopReq,
  input logic [WIDTH-1:0] cntVal
);

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !wrEn && !(modeSel == 2'b11 && trigIn)) |=> $stable(cntVal));

  a_r3_write_reaches_preset: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !(modeSel[1] && trigIn)) |=> (rdData == $past(wrData)));

  a_r3_running_write_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && wrEn && !tickIn && !(modeSel == 2'b11 && trigIn)) |=> $stable(cntVal));

  a_r4_stop_has_event: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |-> ovfPulse);

  a_r7_capture_value: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[1] && trigIn) |=> (ovfPulse && rdData == $past(cntVal)));

  a_r8_capture_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11 && trigIn) |=> (cntVal == '0));

  a_r9_no_stop_in_capture: assert property (@(posedge clk) disable iff (!rstN)
    modeSel[1] |=> !stopReq);

  a_r10_trigger_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel[1] && trigIn && !runBit && !wrEn) |=> (!ovfPulse && $stable(rdData)));

endmodule

bind preset_interval_timer pit_checker #(.WIDTH(WIDTH)) u_pit_checker (
  .clk     (clk),
  .rstN    (rstN),
  .tickIn  (tickIn),
  .runBit  (runBit),
  .modeSel (modeSel),
  .trigIn  (trigIn),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .ovfPulse(ovfPulse),
  .stopReq (stopReq),
  .cntVal  (cntVal)
);

// File: tb/preset_interval_timer_bench.sv
module preset_interval_timer_bench;

  localparam int W = 16;
  localparam int NVEC = 37;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tickIn = 1'b0;
  logic         runBit = 1'b0;
  logic [1:0]   modeSel = 2'b00;
  logic         trigIn = 1'b0;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic         ovfPulse;
  logic         stopReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  preset_interval_timer #(.WIDTH(W)) u_preset_interval_timer (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .runBit(runBit),
    .modeSel(modeSel), .trigIn(trigIn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .ovfPulse(ovfPulse), .stopReq(stopReq)
  );

  // {req[3:0], wr, data[15:0], run, tick, mode[1:0], trig, expRd[15:0], expOvf, expStop}
  localparam logic [43:0] VEC [NVEC] = '{
    // R3 stopped write, single mode
    {4'd3, 1'b1, 16'hFFFD, 1'b0, 1'b0, 2'd0, 1'b0, 16'hFFFD, 1'b0, 1'b0},
    // R2 counting: FFFE, hold, FFFF
    {4'd2, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd0, 1'b0, 16'hFFFD, 1'b0, 1'b0},
    {4'd2, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd0, 1'b0, 16'hFFFD, 1'b0, 1'b0},
    {4'd2, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd0, 1'b0, 16'hFFFD, 1'b0, 1'b0},
    // R4 wrap in single mode
    {4'd4, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd0, 1'b0, 16'hFFFD, 1'b1, 1'b1},
    // R5 frozen after wrap, then capture shows 0
    {4'd5, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd0, 1'b0, 16'hFFFD, 1'b0, 1'b0},
    {4'd5, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd2, 1'b1, 16'h0000, 1'b1, 1'b0},
    // R3 then R6 repeat mode
    {4'd3, 1'b1, 16'hFFFE, 1'b0, 1'b0, 2'd1, 1'b0, 16'hFFFE, 1'b0, 1'b0},
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd1, 1'b0, 16'hFFFE, 1'b0, 1'b0},
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd1, 1'b0, 16'hFFFE, 1'b1, 1'b0},
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd1, 1'b0, 16'hFFFE, 1'b0, 1'b0},
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd1, 1'b0, 16'hFFFE, 1'b1, 1'b0},
    // R3 running write: preset only
    {4'd3, 1'b1, 16'h0005, 1'b1, 1'b0, 2'd1, 1'b0, 16'h0005, 1'b0, 1'b0},
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd1, 1'b0, 16'h0005, 1'b0, 1'b0},
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd1, 1'b0, 16'h0005, 1'b1, 1'b0},
    {4'd2, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd1, 1'b0, 16'h0005, 1'b0, 1'b0},
    // R7 stopped capture shows reloaded+1
    {4'd7, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd2, 1'b1, 16'h0006, 1'b1, 1'b0},
    {4'd2, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd2, 1'b0, 16'h0006, 1'b0, 1'b0},
    // R7 capture with coincident tick takes pre-increment value
    {4'd7, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd2, 1'b1, 16'h0007, 1'b1, 1'b0},
    // R9 natural wrap in capture mode
    {4'd3, 1'b1, 16'hFFFF, 1'b0, 1'b0, 2'd2, 1'b0, 16'hFFFF, 1'b0, 1'b0},
    {4'd9, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd2, 1'b0, 16'hFFFF, 1'b1, 1'b0},
    {4'd2, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd2, 1'b0, 16'hFFFF, 1'b0, 1'b0},
    {4'd7, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd2, 1'b1, 16'h0001, 1'b1, 1'b0},
    // R8 capture and zero, tick in same cycle
    {4'd8, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd3, 1'b1, 16'h0001, 1'b1, 1'b0},
    {4'd2, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd3, 1'b0, 16'h0001, 1'b0, 1'b0},
    {4'd2, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd3, 1'b0, 16'h0001, 1'b0, 1'b0},
    {4'd8, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd3, 1'b1, 16'h0002, 1'b1, 1'b0},
    {4'd8, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd3, 1'b1, 16'h0000, 1'b1, 1'b0},
    // R10 trigger ignored in interval modes, R2 no advance when stopped
    {4'd3, 1'b1, 16'h00AA, 1'b0, 1'b0, 2'd0, 1'b0, 16'h00AA, 1'b0, 1'b0},
    {4'd10,1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b1, 16'h00AA, 1'b0, 1'b0},
    {4'd10,1'b0, 16'h0000, 1'b0, 1'b0, 2'd1, 1'b1, 16'h00AA, 1'b0, 1'b0},
    {4'd2, 1'b0, 16'h0000, 1'b0, 1'b1, 2'd2, 1'b0, 16'h00AA, 1'b0, 1'b0},
    {4'd10,1'b0, 16'h0000, 1'b0, 1'b0, 2'd2, 1'b1, 16'h00AA, 1'b1, 1'b0},
    // R9 wrap in mode 11
    {4'd3, 1'b1, 16'hFFFF, 1'b0, 1'b0, 2'd3, 1'b0, 16'hFFFF, 1'b0, 1'b0},
    {4'd9, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd3, 1'b0, 16'hFFFF, 1'b1, 1'b0},
    // R7 capture beats a stopped write; the write still loads the counter
    {4'd7, 1'b1, 16'h1234, 1'b0, 1'b0, 2'd2, 1'b1, 16'h0000, 1'b1, 1'b0},
    {4'd7, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd2, 1'b1, 16'h1234, 1'b1, 1'b0}
  };

  task automatic checkOut(input int req, input logic [W-1:0] eRd,
                          input logic eOvf, input logic eStop);
    checks++;
    if (rdData !== eRd || ovfPulse !== eOvf || stopReq !== eStop) begin
      errors++;
      $display("FAIL R%0d: rd=%h ovf=%b stop=%b expected rd=%h ovf=%b stop=%b",
               req, rdData, ovfPulse, stopReq, eRd, eOvf, eStop);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkOut(1, '0, 1'b0, 1'b0);  // R1 reset state
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {wrEn, wrData, runBit, tickIn, modeSel, trigIn} = VEC[i][39:18];
      @(posedge clk);
      #1;
      checkOut(int'(VEC[i][43:40]), VEC[i][17:2], VEC[i][1], VEC[i][0]);
    end

    // Outputs are single-cycle pulses: idle cycle drops them (R4, R9).
    @(negedge clk);
    {wrEn, runBit, tickIn, trigIn} = '0;
    @(posedge clk);
    #1;
    checkOut(4, 16'h1234, 1'b0, 1'b0);

    // R1 reset in the middle of operation clears everything.
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    checkOut(1, '0, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    finish();
  end

endmodule